// File: doc/BRIEF.md
# Eviction Originator Tracking Table

This block ties a conflict miss back to the instruction whose earlier miss pushed the wanted line out of a set-associative cache model. Each time a miss replaces a valid line, the replaced line's tag is written into a small direct-indexed table, together with the program counter of the instruction that missed. When a later access to a line is classified as a conflict miss, the block looks up that line's tag in the table. If the line is found, the block returns the stored program counter as the evictor.

The table has a fixed depth of a power of two. Its index is a fold of the tag: the upper half of the tag is XORed with the lower half, and the result is cut down to the index width. A single table entry is touched per lookup. A newer record at the same index replaces the older one. The result comes out one clock after the event, with its own valid strobe.

Top module: `evict_origin_table`

## Requirements
- R1: An event with `ev_valid`=1 and `ev_evict_valid`=1 stores `ev_evict_tag` and `ev_pc` in the entry selected by the hash of `ev_evict_tag`, and marks that entry valid.
- R2: An event with `ev_evict_valid`=0, and any cycle with `ev_valid`=0, leaves the table unchanged.
- R3: `res_valid` is 1 in the cycle after an event with `ev_valid`=1 and `ev_conflict`=1, and 0 after any other cycle.
- R4: If the entry at the hash of `ev_tag` is valid and its stored tag equals `ev_tag`, the result has `res_found`=1 and `res_pc` equal to the stored program counter.
- R5: The index is computed as `(tag[TAG_W-1:TAG_W/2] ^ tag[TAG_W/2-1:0])`, keeping only the low `IDX_W` bits. With the bench configuration (TAG_W=8, IDX_W=2), the index is `tag[5:4]^tag[1:0]`.
- R6: A record replaces any older record at the same index, even if the older record has a different tag.
- R7: If the selected entry is invalid or holds a different tag, the result has `res_found`=0 and `res_pc`=0.
- R8: When one event both records and looks up, the lookup sees the table contents from before that event's write.
- R9: Reset clears the valid bit of every entry, so a lookup made after reset reports not found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | A miss event is present this cycle |
| ev_pc | input | PC_W | Program counter of the instruction that missed |
| ev_evict_valid | input | 1 | The miss replaced a valid line |
| ev_evict_tag | input | TAG_W | Tag of the line that was replaced |
| ev_conflict | input | 1 | The current access is a conflict miss |
| ev_tag | input | TAG_W | Tag of the line being accessed |
| res_valid | output | 1 | Strobe: a lookup result is present |
| res_found | output | 1 | The accessed tag was found in the table |
| res_pc | output | PC_W | Program counter of the evictor, or 0 if not found |

## Verification
The hardest case to reach is an event that writes and reads the same index in one cycle, while the entry still holds a different tag. The bench gets there by first filling every index with one set of tags. It then sends events that record a tag and look up that same tag at once, and expects not found; the next lookup must then report the recorded program counter. Collisions are forced by picking tags whose upper and lower halves XOR to the same index. The full 256-tag sweep tests the fold against the bench's arithmetic model on every entry.

// File: rtl/eot_pkg.sv
package eot_pkg;
   // Smallest index the table accepts (two entries)
   localparam int unsigned EOT_MIN_IDX_W = 1;
   // Smallest program counter width accepted
   localparam int unsigned EOT_MIN_PC_W  = 1;

   typedef enum logic [0:0] {
      EOT_NOT_FOUND = 1'b0,
      EOT_FOUND     = 1'b1
   } eot_hit_e;
endpackage

// File: rtl/eot_hash.sv
module eot_hash #(
   parameter int unsigned TAG_W = 32,
   parameter int unsigned IDX_W = 8
) (
   input  logic [TAG_W-1:0] tag,
   output logic [IDX_W-1:0] idx
);
   localparam int unsigned HALF_W = TAG_W / 2;

   logic [HALF_W-1:0] folded;
   assign folded = tag[TAG_W-1 -: HALF_W] ^ tag[HALF_W-1:0];

   generate
      if (IDX_W == HALF_W) begin : g_full
         assign idx = folded;
      end else begin : g_trunc
         logic unused_hi;
         assign unused_hi = ^folded[HALF_W-1:IDX_W];
         assign idx = folded[IDX_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/eot_store.sv
module eot_store #(
   parameter int unsigned TAG_W = 32,
   parameter int unsigned PC_W  = 48,
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_pc,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic [PC_W-1:0]  rd_pc
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DEPTH-1:0] ent_valid;
   logic [TAG_W-1:0] ent_tag [DEPTH];
   logic [PC_W-1:0]  ent_pc  [DEPTH];

   // Valid bits carry the reset; payload needs none
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ent_valid <= '0;
      else if (wr_en)
         ent_valid[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         ent_tag[wr_idx] <= wr_tag;
         ent_pc[wr_idx]  <= wr_pc;
      end
   end

   // Read port returns pre-write contents for this cycle
   assign rd_valid = ent_valid[rd_idx];
   assign rd_tag   = ent_tag[rd_idx];
   assign rd_pc    = ent_pc[rd_idx];

   assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ent_valid[$past(wr_idx)] && ent_tag[$past(wr_idx)] == $past(wr_tag)
                 && ent_pc[$past(wr_idx)] == $past(wr_pc)));

   assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ent_valid == '0));
endmodule

// File: rtl/eot_lookup.sv
module eot_lookup #(
   parameter int unsigned TAG_W = 32,
   parameter int unsigned PC_W  = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             q_valid,
   input  logic [TAG_W-1:0] q_tag,
   input  logic             rd_valid,
   input  logic [TAG_W-1:0] rd_tag,
   input  logic [PC_W-1:0]  rd_pc,
   output logic             res_valid,
   output logic             res_found,
   output logic [PC_W-1:0]  res_pc
);
   import eot_pkg::*;

   eot_hit_e hit;
   assign hit = (q_valid && rd_valid && (rd_tag == q_tag)) ? EOT_FOUND : EOT_NOT_FOUND;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_found <= 1'b0;
         res_pc    <= '0;
      end else begin
         res_valid <= q_valid;
         res_found <= (hit == EOT_FOUND);
         res_pc    <= (hit == EOT_FOUND) ? rd_pc : '0;
      end
   end

   assert_found_has_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      res_found |-> res_valid);

   assert_miss_zero_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !res_found |-> (res_pc == '0));
endmodule

// File: rtl/evict_origin_table.sv
module evict_origin_table #(
   parameter int unsigned TAG_W = 32,
   parameter int unsigned PC_W  = 48,
   parameter int unsigned IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_valid,
   input  logic [PC_W-1:0]  ev_pc,
   input  logic             ev_evict_valid,
   input  logic [TAG_W-1:0] ev_evict_tag,
   input  logic             ev_conflict,
   input  logic [TAG_W-1:0] ev_tag,
   output logic             res_valid,
   output logic             res_found,
   output logic [PC_W-1:0]  res_pc
);
   import eot_pkg::*;

   generate
      if (TAG_W % 2 != 0) begin : g_chk_even
         $error("TAG_W must be even for the fold hash");
      end
      if (IDX_W < EOT_MIN_IDX_W || IDX_W > TAG_W / 2) begin : g_chk_idx
         $error("IDX_W must lie between 1 and TAG_W/2");
      end
      if (PC_W < EOT_MIN_PC_W) begin : g_chk_pc
         $error("PC_W must be at least 1");
      end
   endgenerate

   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;
   logic             wr_en;
   logic             q_valid;
   logic             rd_valid;
   logic [TAG_W-1:0] rd_tag;
   logic [PC_W-1:0]  rd_pc;

   assign wr_en   = ev_valid && ev_evict_valid;
   assign q_valid = ev_valid && ev_conflict;

   eot_hash #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_hash_wr (
      .tag (ev_evict_tag),
      .idx (wr_idx)
   );

   eot_hash #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_hash_rd (
      .tag (ev_tag),
      .idx (rd_idx)
   );

   eot_store #(.TAG_W(TAG_W), .PC_W(PC_W), .IDX_W(IDX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_tag   (ev_evict_tag),
      .wr_pc    (ev_pc),
      .rd_idx   (rd_idx),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_pc    (rd_pc)
   );

   eot_lookup #(.TAG_W(TAG_W), .PC_W(PC_W)) u_lookup (
      .clk       (clk),
      .rst_n     (rst_n),
      .q_valid   (q_valid),
      .q_tag     (ev_tag),
      .rd_valid  (rd_valid),
      .rd_tag    (rd_tag),
      .rd_pc     (rd_pc),
      .res_valid (res_valid),
      .res_found (res_found),
      .res_pc    (res_pc)
   );

   assert_strobe_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid == ($past(ev_valid && ev_conflict) && $past(rst_n)));
endmodule

// File: tb/evict_origin_table_bench.sv
`timescale 1ns/1ps
module evict_origin_table_bench;
   localparam int TW = 8;
   localparam int PW = 8;
   localparam int IW = 2;
   localparam int DEP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ev_valid = 1'b0;
   logic [PW-1:0] ev_pc = '0;
   logic          ev_evict_valid = 1'b0;
   logic [TW-1:0] ev_evict_tag = '0;
   logic          ev_conflict = 1'b0;
   logic [TW-1:0] ev_tag = '0;
   logic          res_valid;
   logic          res_found;
   logic [PW-1:0] res_pc;

   int n_cmp = 0;
   int n_bad = 0;

   logic          m_valid [DEP];
   logic [TW-1:0] m_tag   [DEP];
   logic [PW-1:0] m_pc    [DEP];

   always #2.5 clk = ~clk;

   evict_origin_table #(.TAG_W(TW), .PC_W(PW), .IDX_W(IW)) u_evict_origin_table (
      .clk            (clk),
      .rst_n          (rst_n),
      .ev_valid       (ev_valid),
      .ev_pc          (ev_pc),
      .ev_evict_valid (ev_evict_valid),
      .ev_evict_tag   (ev_evict_tag),
      .ev_conflict    (ev_conflict),
      .ev_tag         (ev_tag),
      .res_valid      (res_valid),
      .res_found      (res_found),
      .res_pc         (res_pc)
   );

   // R5 index arithmetic for TAG_W=8, IDX_W=2
   function automatic logic [1:0] hidx(input logic [7:0] t);
      return t[5:4] ^ t[1:0];
   endfunction

   function automatic void model_clear();
      for (int i = 0; i < DEP; i++) m_valid[i] = 1'b0;
   endfunction

   task automatic print_summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Drive at negedge, check at the following negedge
   task automatic send(input bit v, input bit evv, input logic [7:0] etag,
                       input logic [7:0] pc, input bit cf, input logic [7:0] tag,
                       input string req);
      logic [1:0] ix;
      logic e_v, e_f;
      logic [7:0] e_pc;
      logic [9:0] got, exp;
      ix   = hidx(tag);
      e_v  = v && cf;
      e_f  = e_v && m_valid[ix] && (m_tag[ix] == tag);
      e_pc = e_f ? m_pc[ix] : 8'h00;
      if (v && evv) begin
         m_valid[hidx(etag)] = 1'b1;
         m_tag[hidx(etag)]   = etag;
         m_pc[hidx(etag)]    = pc;
      end
      ev_valid = v; ev_evict_valid = evv; ev_evict_tag = etag;
      ev_pc = pc; ev_conflict = cf; ev_tag = tag;
      @(negedge clk);
      ev_valid = 1'b0; ev_evict_valid = 1'b0; ev_conflict = 1'b0;
      got = {res_valid, res_found, res_pc};
      exp = {e_v, e_f, e_pc};
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: tag %02h got v/f/pc=%03h expected %03h", req, tag, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      print_summary();
      $finish;
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      // R9 reset state of the strobe
      n_cmp++;
      if (res_valid !== 1'b0 || res_found !== 1'b0) begin
         n_bad++;
         $display("FAIL R9: reset outputs got %b%b expected 00", res_valid, res_found);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R9 / R7: empty table, every tag misses
      for (int t = 0; t < 256; t++) send(1, 0, 8'h00, 8'h00, 1, 8'(t), "R9");

      // R2: events that do not evict, and idle cycles, record nothing
      for (int t = 0; t < 256; t += 7) send(1, 0, 8'(t), 8'hEE, 0, 8'h00, "R2");
      for (int t = 0; t < 256; t += 9) send(0, 1, 8'(t), 8'hDD, 1, 8'(t), "R3");
      for (int t = 0; t < 256; t += 7) send(1, 0, 8'h00, 8'h00, 1, 8'(t), "R2");

      // R1 / R4 / R5: record each tag, then look it up and look up its predecessor
      for (int t = 0; t < 256; t++) begin
         send(1, 1, 8'(t), 8'(t) ^ 8'h5A, 0, 8'h00, "R1");
         send(1, 0, 8'h00, 8'h00, 1, 8'(t), "R4");
         send(1, 0, 8'h00, 8'h00, 1, 8'(t - 1), "R5");
      end

      // R6 / R7: collision at index 0 (tags 00 and 11 both fold to 0)
      send(1, 1, 8'h00, 8'h11, 0, 8'h00, "R6");
      send(1, 1, 8'h11, 8'h22, 0, 8'h00, "R6");
      send(1, 0, 8'h00, 8'h00, 1, 8'h00, "R6");
      send(1, 0, 8'h00, 8'h00, 1, 8'h11, "R6");
      send(1, 0, 8'h00, 8'h00, 1, 8'h33, "R7");

      // R3: conflict flag low gives no strobe
      send(1, 1, 8'h40, 8'h01, 0, 8'h40, "R3");
      send(1, 0, 8'h00, 8'h00, 1, 8'h40, "R3");

      // R8: same event records and looks up the same tag over an older record
      for (int t = 0; t < 16; t++) begin
         send(1, 1, 8'(t * 13 + 128), 8'(t + 100), 1, 8'(t * 13 + 128), "R8");
         send(1, 0, 8'h00, 8'h00, 1, 8'(t * 13 + 128), "R8");
      end

      // R9: reset in mid-run wipes the table
      do_reset();
      for (int t = 0; t < 256; t += 5) send(1, 0, 8'h00, 8'h00, 1, 8'(t), "R9");
      send(1, 1, 8'hA5, 8'h77, 0, 8'h00, "R1");
      send(1, 0, 8'h00, 8'h00, 1, 8'hA5, "R1");

      print_summary();
      $finish;
   end
endmodule